// File: doc/BRIEF.md
# USB Device Port Status and Control Register

This block holds the 32-bit status and control word of one USB device-controller port. Hardware event inputs keep it current: connect level, detected speed, port reset level, warm reset level, a port-enable pulse and link state reports. Software reads the word as one dword and writes it as one dword. Each field keeps its own access rule. Some fields are read-only mirrors of hardware. Some are change flags that software clears by writing 1. The link state field only takes a software value when a strobe bit is set in the same write. The wake enables are plain read-write bits.

The change flags capture events that software must see: a connect edge, the end of a port reset, and a defined set of link state transitions. While any change flag is set, the block drives a single port-change request to the controller status logic. The link training machine reports the link state as a 4-bit code. This block does not run the link.

Top module: `usb_port_stsctl`

## Requirements
- R1: After reset the word reads 0x000000A0. All bits are 0 except the link state field (bits 8:5), which holds RxDetect (code 5).
- R2: Bit 0 (connect) and bits 13:10 (speed code: 0 undefined, 1 full, 3 high, 4 SuperSpeed, 5 and above SuperSpeedPlus, 2 reserved) show the hardware inputs one cycle after they change. Software writes to these bits have no effect.
- R3: Bits 1, 17, 21 and 22 clear when software writes 1 to them. Writing 0 to any of them leaves it unchanged.
- R4: A software write changes the link state field (bits 8:5) only when bit 16 of the same write is 1. Bit 16 always reads 0.
- R5: A hardware link report (valid with a code) loads bits 8:5 on the next cycle. If a strobed software write arrives in the same cycle, the hardware report wins.
- R6: The connect change flag (bit 17) sets on either edge of the connect input.
- R7: The reset change flag (bit 21) sets when the port reset bit (bit 4, mirroring the reset input) falls from 1 to 0.
- R8: The link change flag (bit 22) sets when a hardware report moves the link along one of these transitions: U3(3)→Resume(15), Recovery(8)→U0(0), Resume→U0, U3→U0, U2(2)→U0, U0→Disabled(4), or any state other than Inactive(6)→Inactive. Other transitions, a repeated Inactive report and software writes do not set it.
- R9: Bits 25 (wake on connect) and 26 (wake on disconnect) are plain read-write bits.
- R10: When a hardware set and a software write-1-to-clear hit a change flag in the same cycle, the flag ends up set.
- R11: The port_change output is high exactly while bit 17, 21 or 22 is set. Bit 1 does not drive it.
- R12: A pulse on the port-enable input sets bit 1. Bit 31 mirrors the warm reset input one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Dword write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register word |
| hw_connect | input | 1 | Connect level from the port |
| hw_speed | input | 4 | Detected speed code |
| hw_reset_active | input | 1 | Port reset signalling in progress |
| hw_warm_reset | input | 1 | Warm reset being received |
| hw_port_enable | input | 1 | Pulse: port has been enabled |
| hw_link_valid | input | 1 | A link state report is present |
| hw_link_code | input | 4 | Reported link state code |
| port_change | output | 1 | Port change request to status logic |

## Verification
The properties assume that every input is synchronous to clk and that the link code is meaningful only while its valid bit is high. They also assume that nothing is sampled while rst_n is low. The stimulus changes inputs only at the falling edge and holds each level for a whole cycle. It drives the link code only together with the valid bit, and it raises a write and a hardware event in the same cycle only in the vectors that test priority. Link reports move through the states in an order where each qualifying and non-qualifying transition appears at least once, so every property's antecedent is reached.

// File: rtl/psc_pkg.sv
package psc_pkg;

   typedef enum logic [3:0] {
      LNK_U0         = 4'd0,
      LNK_U1         = 4'd1,
      LNK_U2         = 4'd2,
      LNK_U3         = 4'd3,
      LNK_DISABLED   = 4'd4,
      LNK_RXDETECT   = 4'd5,
      LNK_INACTIVE   = 4'd6,
      LNK_POLLING    = 4'd7,
      LNK_RECOVERY   = 4'd8,
      LNK_HOTRESET   = 4'd9,
      LNK_COMPLIANCE = 4'd10,
      LNK_TEST       = 4'd11,
      LNK_RESUME     = 4'd15
   } link_e;

   // Field positions software decodes
   localparam int BIT_CONN      = 0;
   localparam int BIT_EN        = 1;
   localparam int BIT_RST       = 4;
   localparam int LINK_LO       = 5;
   localparam int LINK_HI       = 8;
   localparam int SPEED_LO      = 10;
   localparam int SPEED_HI      = 13;
   localparam int BIT_STROBE    = 16;
   localparam int BIT_CSC       = 17;
   localparam int BIT_RC        = 21;
   localparam int BIT_PLC       = 22;
   localparam int BIT_WAKE_CONN = 25;
   localparam int BIT_WAKE_DISC = 26;
   localparam int BIT_WARM      = 31;

   // Write-1-to-clear flag bank
   localparam int NUM_FLAGS = 4;
   localparam int FLAG_EN   = 0;
   localparam int FLAG_CSC  = 1;
   localparam int FLAG_RC   = 2;
   localparam int FLAG_PLC  = 3;
   localparam int FLAG_POS [NUM_FLAGS] = '{BIT_EN, BIT_CSC, BIT_RC, BIT_PLC};

endpackage

// File: rtl/psc_change_flag.sv
module psc_change_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   // A set in the same cycle as a clear takes priority
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

endmodule

// File: rtl/psc_link_watch.sv
module psc_link_watch
   import psc_pkg::*;
(
   input  logic       upd_i,
   input  logic [3:0] cur_i,
   input  logic [3:0] nxt_i,
   output logic       hit_o
);

   logic to_u0, to_resume, to_disabled, to_inactive;

   always_comb begin
      to_u0       = (nxt_i == LNK_U0) &&
                    ((cur_i == LNK_RECOVERY) || (cur_i == LNK_RESUME) ||
                     (cur_i == LNK_U3)       || (cur_i == LNK_U2));
      to_resume   = (cur_i == LNK_U3) && (nxt_i == LNK_RESUME);
      to_disabled = (cur_i == LNK_U0) && (nxt_i == LNK_DISABLED);
      to_inactive = (cur_i != LNK_INACTIVE) && (nxt_i == LNK_INACTIVE);
      hit_o       = upd_i && (to_u0 || to_resume || to_disabled || to_inactive);
   end

endmodule

// File: rtl/usb_port_stsctl.sv
module usb_port_stsctl
   import psc_pkg::*;
#(
   parameter int         REG_W      = 32,
   parameter int         SPEED_W    = 4,
   parameter int         LINK_W     = 4,
   parameter logic [3:0] RESET_LINK = 4'd5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rd_data,
   input  logic               hw_connect,
   input  logic [SPEED_W-1:0] hw_speed,
   input  logic               hw_reset_active,
   input  logic               hw_warm_reset,
   input  logic               hw_port_enable,
   input  logic               hw_link_valid,
   input  logic [LINK_W-1:0]  hw_link_code,
   output logic               port_change
);

   localparam int SPEED_SPAN = SPEED_HI - SPEED_LO + 1;
   localparam int LINK_SPAN  = LINK_HI - LINK_LO + 1;

   // Elaboration checks: field layout is fixed by the software view
   if (REG_W != 32) begin : g_bad_reg_w
      $error("usb_port_stsctl: REG_W must be 32");
   end
   if (SPEED_W != SPEED_SPAN) begin : g_bad_speed_w
      $error("usb_port_stsctl: SPEED_W must match the speed field");
   end
   if (LINK_W != LINK_SPAN) begin : g_bad_link_w
      $error("usb_port_stsctl: LINK_W must match the link field");
   end

   logic               conn_q, rst_q, warm_q;
   logic [SPEED_W-1:0] speed_q;
   logic [LINK_W-1:0]  link_q, link_nxt;
   logic               wake_conn_q, wake_disc_q;
   logic               sw_link_wr, link_hit;
   logic [NUM_FLAGS-1:0] flag_set, flag_q;
   logic               unused_wr;

   // Hardware mirrors
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conn_q  <= 1'b0;
         rst_q   <= 1'b0;
         warm_q  <= 1'b0;
         speed_q <= '0;
      end else begin
         conn_q  <= hw_connect;
         rst_q   <= hw_reset_active;
         warm_q  <= hw_warm_reset;
         speed_q <= hw_speed;
      end
   end

   // Link state: hardware report beats a strobed software write
   assign sw_link_wr = wr_en && wr_data[BIT_STROBE];

   always_comb begin
      if (hw_link_valid)
         link_nxt = hw_link_code;
      else if (sw_link_wr)
         link_nxt = wr_data[LINK_HI:LINK_LO];
      else
         link_nxt = link_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         link_q <= RESET_LINK;
      else
         link_q <= link_nxt;
   end

   psc_link_watch i_link_watch (
      .upd_i (hw_link_valid),
      .cur_i (link_q),
      .nxt_i (hw_link_code),
      .hit_o (link_hit)
   );

   // Plain read-write wake enables
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_conn_q <= 1'b0;
         wake_disc_q <= 1'b0;
      end else if (wr_en) begin
         wake_conn_q <= wr_data[BIT_WAKE_CONN];
         wake_disc_q <= wr_data[BIT_WAKE_DISC];
      end
   end

   // Change flag sources
   always_comb begin
      flag_set           = '0;
      flag_set[FLAG_EN]  = hw_port_enable;
      flag_set[FLAG_CSC] = hw_connect ^ conn_q;
      flag_set[FLAG_RC]  = rst_q & ~hw_reset_active;
      flag_set[FLAG_PLC] = link_hit;
   end

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      psc_change_flag i_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (flag_set[g]),
         .clr_i  (wr_en && wr_data[FLAG_POS[g]]),
         .flag_o (flag_q[g])
      );
   end

   // Read view
   always_comb begin
      rd_data                     = '0;
      rd_data[BIT_CONN]           = conn_q;
      rd_data[BIT_RST]            = rst_q;
      rd_data[LINK_HI:LINK_LO]    = link_q;
      rd_data[SPEED_HI:SPEED_LO]  = speed_q;
      rd_data[BIT_WAKE_CONN]      = wake_conn_q;
      rd_data[BIT_WAKE_DISC]      = wake_disc_q;
      rd_data[BIT_WARM]           = warm_q;
      for (int i = 0; i < NUM_FLAGS; i++)
         rd_data[FLAG_POS[i]] = flag_q[i];
   end

   assign port_change = flag_q[FLAG_CSC] | flag_q[FLAG_RC] | flag_q[FLAG_PLC];

   assign unused_wr = ^{wr_data[31:27], wr_data[24:23], wr_data[20:18],
                        wr_data[15:9], wr_data[4:2], wr_data[0]};

endmodule

// File: rtl/psc_checker.sv
module psc_checker
   import psc_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic [31:0] wr_data,
   input logic        hw_connect,
   input logic        hw_reset_active,
   input logic        hw_link_valid,
   input logic [3:0]  hw_link_code,
   input logic [31:0] rd_data,
   input logic        port_change
);

   // R3: clearing the connect flag with no fresh edge empties it
   assert_csc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_CSC] && (hw_connect == rd_data[BIT_CONN]))
      |=> !rd_data[BIT_CSC]);

   // R4: without strobe or hardware report the link field holds
   assert_link_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[BIT_STROBE] && !hw_link_valid)
      |=> $stable(rd_data[LINK_HI:LINK_LO]));

   // R6 / R11: a connect edge raises the flag and the request
   assert_csc_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_connect != rd_data[BIT_CONN]) |=> (rd_data[BIT_CSC] && port_change));

   // R7: falling reset raises the reset change flag
   assert_rc_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[BIT_RST] && !hw_reset_active) |=> rd_data[BIT_RC]);

   // R8: entry to Inactive raises the link change flag
   assert_plc_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_link_valid && (hw_link_code == LNK_INACTIVE) &&
       (rd_data[LINK_HI:LINK_LO] != LNK_INACTIVE)) |=> rd_data[BIT_PLC]);

   // R11: no change flag, no request
   assert_no_flag_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_data[BIT_CSC] || rd_data[BIT_RC] || rd_data[BIT_PLC]) |-> !port_change);

   // R4: the strobe bit never reads back
   assert_strobe_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[BIT_STROBE]);

endmodule

bind usb_port_stsctl psc_checker i_psc_checker (
   .clk             (clk),
   .rst_n           (rst_n),
   .wr_en           (wr_en),
   .wr_data         (wr_data),
   .hw_connect      (hw_connect),
   .hw_reset_active (hw_reset_active),
   .hw_link_valid   (hw_link_valid),
   .hw_link_code    (hw_link_code),
   .rd_data         (rd_data),
   .port_change     (port_change)
);

// File: tb/test_usb_port_stsctl.sv
module test_usb_port_stsctl;

   typedef struct packed {
      logic [23:0] tag;
      logic        wr;
      logic [31:0] wd;
      logic        conn;
      logic [3:0]  spd;
      logic        rst;
      logic        lv;
      logic [3:0]  lc;
      logic        en;
      logic        warm;
      logic [31:0] exp;
      logic        pc;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t VECS [NV] = '{
      '{"R6 ",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h000210A1,1'b1},
      '{"R3 ",1'b1,32'h00020000,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h000010A1,1'b0},
      '{"R7 ",1'b0,32'h00000000,1'b1,4'd4,1'b1,1'b0,4'd0, 1'b0,1'b0,32'h000010B1,1'b0},
      '{"R12",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b1,1'b0,32'h002010A3,1'b1},
      '{"R3 ",1'b1,32'h00200002,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h000010A1,1'b0},
      '{"R2 ",1'b1,32'h00003C60,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h000010A1,1'b0},
      '{"R4 ",1'b1,32'h06010000,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h06001001,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b1,4'd2, 1'b0,1'b0,32'h06001041,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b1,4'd0, 1'b0,1'b0,32'h06401001,1'b1},
      '{"R10",1'b1,32'h06400000,1'b1,4'd4,1'b0,1'b1,4'd4, 1'b0,1'b0,32'h06401081,1'b1},
      '{"R9 ",1'b1,32'h00400000,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h00001081,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b1,4'd6, 1'b0,1'b0,32'h004010C1,1'b1},
      '{"R3 ",1'b1,32'h00400000,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h000010C1,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b1,4'd3, 1'b0,1'b0,32'h00001061,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b1,4'd15,1'b0,1'b0,32'h004011E1,1'b1},
      '{"R10",1'b1,32'h00400000,1'b1,4'd4,1'b0,1'b1,4'd0, 1'b0,1'b0,32'h00401001,1'b1},
      '{"R3 ",1'b1,32'h00400000,1'b1,4'd4,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h00001001,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b1,4'd8, 1'b0,1'b0,32'h00001101,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd4,1'b0,1'b1,4'd0, 1'b0,1'b0,32'h00401001,1'b1},
      '{"R8 ",1'b1,32'h00400000,1'b1,4'd4,1'b0,1'b1,4'd7, 1'b0,1'b0,32'h000010E1,1'b0},
      '{"R12",1'b0,32'h00000000,1'b0,4'd0,1'b0,1'b0,4'd0, 1'b0,1'b1,32'h800200E0,1'b1},
      '{"R10",1'b1,32'h00020000,1'b1,4'd0,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h000200E1,1'b1},
      '{"R11",1'b1,32'h00020000,1'b1,4'd0,1'b0,1'b1,4'd3, 1'b0,1'b0,32'h00000061,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd0,1'b0,1'b1,4'd0, 1'b0,1'b0,32'h00400001,1'b1},
      '{"R8 ",1'b1,32'h00400000,1'b1,4'd0,1'b0,1'b1,4'd6, 1'b0,1'b0,32'h004000C1,1'b1},
      '{"R3 ",1'b1,32'h00400000,1'b1,4'd0,1'b0,1'b0,4'd0, 1'b0,1'b0,32'h000000C1,1'b0},
      '{"R8 ",1'b0,32'h00000000,1'b1,4'd0,1'b0,1'b1,4'd6, 1'b0,1'b0,32'h000000C1,1'b0},
      '{"R5 ",1'b1,32'h00010060,1'b1,4'd0,1'b0,1'b1,4'd0, 1'b0,1'b0,32'h00000001,1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        hw_connect = 1'b0;
   logic [3:0]  hw_speed = '0;
   logic        hw_reset_active = 1'b0;
   logic        hw_warm_reset = 1'b0;
   logic        hw_port_enable = 1'b0;
   logic        hw_link_valid = 1'b0;
   logic [3:0]  hw_link_code = '0;
   logic        port_change;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   usb_port_stsctl i_usb_port_stsctl (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_en           (wr_en),
      .wr_data         (wr_data),
      .rd_data         (rd_data),
      .hw_connect      (hw_connect),
      .hw_speed        (hw_speed),
      .hw_reset_active (hw_reset_active),
      .hw_warm_reset   (hw_warm_reset),
      .hw_port_enable  (hw_port_enable),
      .hw_link_valid   (hw_link_valid),
      .hw_link_code    (hw_link_code),
      .port_change     (port_change)
   );

   task automatic check(input string req, input logic [31:0] exp_w, input logic exp_pc);
      checks++;
      if (rd_data !== exp_w || port_change !== exp_pc) begin
         errors++;
         $display("FAIL %s: rd_data=%08h port_change=%b expected %08h %b",
                  req, rd_data, port_change, exp_w, exp_pc);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 32'h000000A0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'h000000A0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         wr_en           = VECS[i].wr;
         wr_data         = VECS[i].wd;
         hw_connect      = VECS[i].conn;
         hw_speed        = VECS[i].spd;
         hw_reset_active = VECS[i].rst;
         hw_link_valid   = VECS[i].lv;
         hw_link_code    = VECS[i].lc;
         hw_port_enable  = VECS[i].en;
         hw_warm_reset   = VECS[i].warm;
         @(posedge clk);
         @(negedge clk);
         check(string'(VECS[i].tag), VECS[i].exp, VECS[i].pc);
      end

      // R1: reset in mid-run returns every field to its reset value
      wr_en         = 1'b1;
      wr_data       = 32'h06000000;
      hw_link_valid = 1'b0;
      @(negedge clk);
      check("R9", 32'h06000001, 1'b0);
      wr_en      = 1'b0;
      hw_connect = 1'b0;
      rst_n      = 1'b0;
      #1;
      check("R1", 32'h000000A0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'h000000A0, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule